// File: doc/BRIEF.md
# Variable-Frequency NCO Clock Generator

This block is a numerically controlled oscillator. It holds a 16-bit phase accumulator. On every reference-clock cycle in which the channel runs, the accumulator grows by an effective step that comes from a 16-bit control word. The top bit of the accumulator is the square-wave output. Its frequency is the step times 2^-16 times the reference frequency. A one-cycle tick marks each rising edge of that output, so that a constant-frequency PWM stage in the same clock domain can count it.

Software loads the control word one byte at a time. A write to the upper byte only stages that byte. A write to the lower byte then commits both bytes at once, so the accumulator never sees a half-written word. A word of 2^15 or more is taken as negative: its 16-bit two's complement is used as the step. When the channel is stopped, the accumulator sits at zero and the output stays low.

Top module: `nco_clkgen`

## Requirements
- R1: While reset (`rst_n` low) is applied, and after it is released, the accumulator is zero. `vf_out` and `vf_tick` are low, and the committed control word and the staged upper byte are both zero.
- R2: A cycle with `hi_we` high and `lo_we` low stores `wdata` as the staged upper byte. It does not change the committed word, so the output sequence continues exactly as before.
- R3: A cycle with `lo_we` high commits the word {staged upper byte, `wdata`}. The new step applies from the next clock edge onward. The accumulator keeps its value across the update and is not cleared.
- R4: The effective step is the committed word when that word is below 0x8000. Otherwise it is (0x10000 - word) mod 0x10000, so 0xF000 gives 0x1000.
- R5: While `run` is high, each clock edge sets the accumulator to (accumulator + step) mod 2^16. `vf_out` equals bit 15 of the accumulator.
- R6: `vf_tick` is high for exactly those cycles in which `vf_out` is high and was low in the previous cycle.
- R7: A clock edge that samples `run` low sets the accumulator to zero. `vf_out` and `vf_tick` are then low in the following cycle.
- R8: A committed word of 2^k (for 0 <= k <= 15) gives a square wave with a period of 2^(16-k) cycles and exactly half of each period high.
- R9: Word 0x8000 gives step 0x8000, so `vf_out` toggles on every cycle while `run` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel start; low holds the accumulator at zero |
| hi_we | input | 1 | Write strobe for the staged upper byte |
| lo_we | input | 1 | Write strobe for the lower byte; commits the whole word |
| wdata | input | 8 | Byte written by either strobe |
| vf_out | output | 1 | Variable-frequency square wave (accumulator MSB) |
| vf_tick | output | 1 | One-cycle pulse on each rising edge of `vf_out` |

## Verification
Stimulus changes on the falling edge, and the design samples it on the next rising edge. A lower-byte write therefore changes the step at the rising edge after the one that captured it, so `vf_out` can first show the new frequency two rising edges after the strobe. A change on `run` shows at `vf_out` after one rising edge. `vf_tick` is combinational with `vf_out` in the same cycle. A behavioural model in the bench steps on each rising edge, and the outputs are compared at every falling edge, so each check reads the value that is due in that cycle. Separate counts of high cycles over whole periods check the power-of-two duty cases.

// File: rtl/nco_clkgen.sv
module nco_clkgen #(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic              vf_out,
  output logic              vf_tick
);
  localparam int HI_W = WORD_W - BYTE_W;

  logic [HI_W-1:0]   hi_stage;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] step;
  logic [WORD_W-1:0] phase;
  logic              msb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_stage <= '0;
      word_q   <= '0;
    end else begin
      if (hi_we) hi_stage <= wdata[HI_W-1:0];
      if (lo_we) word_q   <= {hi_stage, wdata};
    end
  end

  assign step = word_q[WORD_W-1] ? (~word_q + WORD_W'(1)) : word_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase <= '0;
      msb_q <= 1'b0;
    end else begin
      phase <= phase + step;
      msb_q <= phase[WORD_W-1];
    end
  end

  assign vf_out  = phase[WORD_W-1];
  assign vf_tick = vf_out & ~msb_q;

  assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!vf_out && !vf_tick));

  assert_hi_only_stages_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && !lo_we) |=> $stable(word_q));

  assert_tick_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vf_tick |-> (vf_out && !$past(vf_out)));

  assert_phase_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(rst_n)) |-> (phase == $past(phase) + $past(step)));

  assert_half_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(rst_n) && $past(word_q) == 16'h8000) |-> (vf_out != $past(vf_out)));
endmodule

// File: tb/tb_nco_clkgen.sv
module tb_nco_clkgen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic hi_we = 1'b0;
  logic lo_we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic vf_out, vf_tick;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  int m_hi = 0, m_word = 0, m_acc = 0;
  bit prev_out = 1'b0;

  nco_clkgen dut (.clk(clk), .rst_n(rst_n), .run(run), .hi_we(hi_we), .lo_we(lo_we),
                  .wdata(wdata), .vf_out(vf_out), .vf_tick(vf_tick));

  always #5 clk = ~clk;

  function automatic int eff_step(int w);
    if (w < 32768) return w;
    return (65536 - w) % 65536;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_hi = 0; m_word = 0; m_acc = 0;
    end else begin
      if (run) m_acc = (m_acc + eff_step(m_word)) % 65536;
      else m_acc = 0;
      if (lo_we) m_word = m_hi * 256 + wdata;
      if (hi_we) m_hi = wdata;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check("R5 vf_out", vf_out, (m_acc >= 32768) ? 1 : 0);
      check("R6 vf_tick", vf_tick, (vf_out && !prev_out) ? 1 : 0);
      prev_out = vf_out;
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(bit hi, logic [7:0] v);
    @(negedge clk);
    hi_we = hi; lo_we = !hi; wdata = v;
    @(negedge clk);
    hi_we = 1'b0; lo_we = 1'b0;
  endtask

  task automatic set_word(int w);
    wr(1'b1, 8'(w / 256));
    wr(1'b0, 8'(w % 256));
  endtask

  task automatic duty(string req, int cyc, int exp_high);
    int hi_cnt = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (vf_out) hi_cnt++;
    end
    check(req, hi_cnt, exp_high);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset out", vf_out, 0);
    check("R1 reset tick", vf_tick, 0);
    rst_n = 1'b1;
    run = 1'b1;
    repeat (20) @(negedge clk);
    check("R1 zero word holds output low", vf_out, 0);
    // R2: upper byte alone changes nothing
    wr(1'b1, 8'h40);
    repeat (10) @(negedge clk);
    check("R2 staged byte not used", vf_out, 0);
    // R3, R8: commit 0x4000 -> period 4, 2 high
    wr(1'b0, 8'h00);
    @(negedge clk);
    duty("R8 word 0x4000 duty", 64, 32);
    // R4: negative word 0xF000 -> step 0x1000, period 16
    run = 1'b0;
    @(negedge clk);
    check("R7 stop output", vf_out, 0);
    check("R7 stop tick", vf_tick, 0);
    set_word(16'hF000);
    run = 1'b1;
    duty("R4 word 0xF000 duty", 64, 32);
    // R8: 0x0400 -> period 64
    run = 1'b0;
    set_word(16'h0400);
    run = 1'b1;
    duty("R8 word 0x0400 duty", 128, 64);
    // R9: 0x8000 toggles every cycle
    run = 1'b0;
    set_word(16'h8000);
    run = 1'b1;
    duty("R9 word 0x8000 duty", 32, 16);
    // R3: switch word while running, accumulator kept
    set_word(16'h1234);
    repeat (100) @(negedge clk);
    set_word(16'h0001);
    repeat (200) @(negedge clk);
    set_word(16'hABCD);
    repeat (200) @(negedge clk);
    // R2: hi write mid-run does not disturb output
    wr(1'b1, 8'h7F);
    repeat (50) @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 held low", vf_out, 0);
    run = 1'b1;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", vf_out, 0);
    rst_n = 1'b1;
    wr(1'b0, 8'h00);
    repeat (20) @(negedge clk);
    check("R1 staged byte cleared by reset", vf_out, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule